// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block is the platform machine-mode timer. It keeps one free-running 64-bit time counter that all harts share. It also holds one 64-bit compare register for each hart. Each hart has its own level interrupt line. That line is high while the shared counter has reached the hart's compare value. The counter advances by one on every clock cycle in which the tick enable input is high. A platform can drive that input from any slower time base that is already in this clock domain.

Software reaches the block over a 32-bit register port. The port carries a word offset, write data, byte strobes and a request valid. The platform strips its base address, which must be at least 4-byte aligned, so the block sees only the offset.

The compare registers occupy a window at 0x4000, with 8 bytes per hart. The counter sits at 0xBFF8. Each 64-bit register is split into a low word at the lower address and a high word at the next word address.

The port takes one request in every cycle that `bus_valid` is high and never pushes back. There is no accept-side ready. `bus_ready` is a response strobe: it rises in the cycle after each accepted request, and in that cycle `bus_rdata` carries the registered read result. A requester may therefore issue a request on every cycle. It must take each response in the cycle it appears, because responses are not held.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the counter is zero, every compare register reads 0xFFFFFFFF in both halves, and every interrupt output is low.
- R2: The counter increases by exactly one at each clock edge where `tick_en` is high, and holds its value when `tick_en` is low.
- R3: The counter low word is at byte offset 0xBFF8 and its high word at 0xBFFC. A write to either half replaces that half and leaves the other half unchanged, and in that cycle the write takes priority over the increment.
- R4: The compare register of hart n is at byte offset 0x4000 + 8*n, with its low word at +0 and its high word at +4. Both halves are readable and writable.
- R5: Interrupt output n is high whenever the counter, compared unsigned over 64 bits, is greater than or equal to hart n's compare value. After a write that makes the compare value larger than the counter, the output is low on the following cycle.
- R6: Byte strobe bit k selects bits 8k+7..8k of the addressed 32-bit half. Only the selected bytes change on a write.
- R7: Addresses inside the compare window whose hart index is at least NUM_HARTS (up to the last slot at 0xBFF0), and addresses outside both the compare window and the counter, read as zero. Writes to them change no state, and no error is signalled.
- R8: `bus_ready` is high in exactly the cycle after each cycle in which `bus_valid` is high. `bus_rdata` in that cycle holds the addressed word as it was before the request's clock edge, and it is zero for writes and in cycles without a response.
- R9: A write to one hart's compare register leaves every other hart's compare register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable, one increment per high cycle |
| bus_valid | input | 1 | Request present this cycle, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset bits 15..2 (word offset) |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte write enables |
| bus_ready | output | 1 | Response strobe, one cycle after each request |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_HARTS | Level machine timer interrupt per hart |

## Verification
The interrupt compare is driven by two kinds of counter values. Small values are written into both halves with mostly zero high words, so the counter sits close to the compare values and each interrupt crosses its threshold in both directions. Random full-width values exercise the high-word part of the 64-bit unsigned compare, which the small values alone would leave untested.

Directed sequences target specific orderings. A counter write in the same cycle as a tick separates write priority from the increment. A partial-strobe write separates per-byte merging from a whole-word write. Writes to a hart slot beyond the configured count, to the last legal slot at 0xBFF0, and to addresses outside the map separate correct range decoding from aliasing onto real harts.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // Word offsets (byte offset >> 3) of the 64-bit register slots.
  localparam logic [12:0] CMP_SLOT0 = 13'h0800;  // 0x4000
  localparam logic [12:0] TIME_SLOT = 13'h17FF;  // 0xBFF8

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TIME = 2'd1,
    SEL_CMP  = 2'd2
  } sel_e;

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic [15:2] addr,
  output sel_e        sel,
  output logic [12:0] hart_idx,
  output logic        hi_half
);

  localparam logic [12:0] HART_LIMIT = 13'(NUM_HARTS);

  logic [12:0] slot;
  logic [12:0] rel;

  assign slot    = addr[15:3];
  assign hi_half = addr[2];
  assign rel     = slot - CMP_SLOT0;

  always_comb begin
    sel      = SEL_NONE;
    hart_idx = rel;
    if (slot == TIME_SLOT) begin
      sel = SEL_TIME;
    end else if (slot >= CMP_SLOT0 && slot < TIME_SLOT && rel < HART_LIMIT) begin
      sel = SEL_CMP;
    end
  end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic [3:0]       strb,
  output logic [CNT_W-1:0] count
);

  localparam int HALF_W = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_en) begin
      if (wr_hi) begin
        count[CNT_W-1:HALF_W] <= merge_bytes(count[CNT_W-1:HALF_W], wdata, strb);
      end else begin
        count[HALF_W-1:0] <= merge_bytes(count[HALF_W-1:0], wdata, strb);
      end
    end else if (tick_en) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mtimer_cmp_bank.sv
module mtimer_cmp_bank
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [12:0]             wr_idx,
  input  logic                    wr_hi,
  input  logic [31:0]             wdata,
  input  logic [3:0]              strb,
  input  logic [63:0]             now,
  output logic [NUM_HARTS*64-1:0] cmp_flat,
  output logic [NUM_HARTS-1:0]    irq
);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [63:0] cmp_q;
    logic        hit;

    assign hit = wr_en && (wr_idx == 13'(h));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '1;
      end else if (hit) begin
        if (wr_hi) begin
          cmp_q[63:32] <= merge_bytes(cmp_q[63:32], wdata, strb);
        end else begin
          cmp_q[31:0] <= merge_bytes(cmp_q[31:0], wdata, strb);
        end
      end
    end

    assign cmp_flat[h*64 +: 64] = cmp_q;
    assign irq[h]               = (now >= cmp_q);
  end

endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [15:2]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_strb,
  output logic                 bus_ready,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq
);

  sel_e                    sel;
  logic [12:0]             hart_idx;
  logic                    hi_half;
  logic [63:0]             time_q;
  logic [NUM_HARTS*64-1:0] cmp_flat;
  logic [63:0]             cmp_rd;
  logic [31:0]             rd_word;
  logic                    wr_time;
  logic                    wr_cmp;

  mtimer_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
    .addr     (bus_addr),
    .sel      (sel),
    .hart_idx (hart_idx),
    .hi_half  (hi_half)
  );

  assign wr_time = bus_valid && bus_write && (sel == SEL_TIME);
  assign wr_cmp  = bus_valid && bus_write && (sel == SEL_CMP);

  mtimer_counter #(.CNT_W(64)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_time),
    .wr_hi   (hi_half),
    .wdata   (bus_wdata),
    .strb    (bus_strb),
    .count   (time_q)
  );

  mtimer_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cmp),
    .wr_idx   (hart_idx),
    .wr_hi    (hi_half),
    .wdata    (bus_wdata),
    .strb     (bus_strb),
    .now      (time_q),
    .cmp_flat (cmp_flat),
    .irq      (irq)
  );

  always_comb begin
    cmp_rd = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (hart_idx == 13'(h)) cmp_rd = cmp_flat[h*64 +: 64];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_TIME: rd_word = hi_half ? time_q[63:32] : time_q[31:0];
      SEL_CMP:  rd_word = hi_half ? cmp_rd[63:32] : cmp_rd[31:0];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_valid;
      bus_rdata <= (bus_valid && !bus_write) ? rd_word : 32'h0;
    end
  end

endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker #(
  parameter int NUM_HARTS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [15:2]             bus_addr,
  input logic                    bus_ready,
  input logic [31:0]             bus_rdata,
  input logic [63:0]             cnt,
  input logic [NUM_HARTS*64-1:0] cmp_flat,
  input logic [NUM_HARTS-1:0]    irq
);

  logic time_wr;
  logic low_unmapped;

  assign time_wr      = bus_valid && bus_write && (bus_addr[15:3] == 13'h17FF);
  assign low_unmapped = (bus_addr < 14'h1000);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt == 64'h0 && irq == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr) |=> cnt == $past(cnt) + 64'd1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_wr) |=> $stable(cnt));

  p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && low_unmapped) |=> $stable(cmp_flat));

  p_unmapped_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && low_unmapped) |=> bus_rdata == 32'h0);

  p_resp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_ready);

  p_resp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!bus_ready && bus_rdata == 32'h0));

endmodule

bind mtimer_unit mtimer_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_ready (bus_ready),
  .bus_rdata (bus_rdata),
  .cnt       (time_q),
  .cmp_flat  (cmp_flat),
  .irq       (irq)
);

// File: tb/test_mtimer_unit.sv
module test_mtimer_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NH         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          b_tick = 1'b0;
  logic          b_valid = 1'b0;
  logic          b_write = 1'b0;
  logic [15:0]   b_addr = 16'h0;
  logic [31:0]   b_wdata = 32'h0;
  logic [3:0]    b_strb = 4'h0;
  logic          bus_ready;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtimer_unit #(.NUM_HARTS(NH)) i_mtimer_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (b_tick),
    .bus_valid (b_valid),
    .bus_write (b_write),
    .bus_addr  (b_addr[15:2]),
    .bus_wdata (b_wdata),
    .bus_strb  (b_strb),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // ---------------- reference model ----------------
  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];
  logic        m_rdy;
  logic [31:0] m_rd;
  int          m_cls;

  // 0 = unmapped, 1 = counter, 2+n = compare of hart n
  function automatic int classify(input logic [15:0] a);
    int n;
    if (a >= 16'hBFF8) return (a <= 16'hBFFF) ? 1 : 0;
    if (a < 16'h4000) return 0;
    n = int'((a - 16'h4000) >> 3);
    return (n < NH) ? 2 + n : 0;
  endfunction

  function automatic logic [31:0] put_bytes(input logic [31:0] o, input logic [31:0] n,
                                            input logic [3:0] s);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (s[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic logic [NH-1:0] model_irq();
    logic [NH-1:0] v;
    for (int n = 0; n < NH; n++) v[n] = (m_time >= m_cmp[n]);
    return v;
  endfunction

  always @(posedge clk) begin
    int c;
    logic hi;
    logic [63:0] reg64;
    if (!rst_n) begin
      m_time = 64'h0;
      for (int n = 0; n < NH; n++) m_cmp[n] = '1;
      m_rdy = 1'b0;
      m_rd  = 32'h0;
      m_cls = 0;
    end else begin
      c  = classify(b_addr);
      hi = b_addr[2];
      reg64 = (c == 1) ? m_time : (c >= 2) ? m_cmp[c-2] : 64'h0;
      m_rdy = b_valid;
      m_cls = c;
      m_rd  = (b_valid && !b_write) ? (hi ? reg64[63:32] : reg64[31:0]) : 32'h0;
      if (b_valid && b_write && c != 0) begin
        if (hi) reg64[63:32] = put_bytes(reg64[63:32], b_wdata, b_strb);
        else    reg64[31:0]  = put_bytes(reg64[31:0], b_wdata, b_strb);
        if (c == 1) m_time = reg64;
        else        m_cmp[c-2] = reg64;
      end
      if (!(b_valid && b_write && c == 1) && b_tick) m_time = m_time + 64'd1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check("R8 ready", 64'(bus_ready), 64'(m_rdy));
      if (m_rdy)
        check(m_cls == 1 ? "R3 counter read" : m_cls >= 2 ? "R4 compare read" : "R7 unmapped read",
              64'(bus_rdata), 64'(m_rd));
      else
        check("R8 idle rdata", 64'(bus_rdata), 64'h0);
      check("R5 irq level", 64'(irq), 64'(model_irq()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic w, input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] s, input logic t);
    @(negedge clk);
    b_valid = 1'b1; b_write = w; b_addr = a; b_wdata = d; b_strb = s; b_tick = t;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      b_valid = 1'b0; b_write = 1'b0; b_tick = t;
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    op(1'b0, a, 32'h0, 4'h0, 1'b0);
    @(negedge clk);
    b_valid = 1'b0; b_tick = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq after reset", 64'(irq), 64'h0);
    rd(16'hBFF8, v);  check("R1 counter low", 64'(v), 64'h0);
    rd(16'h4014, v);  check("R1 compare hi hart2", 64'(v), 64'hFFFFFFFF);
    // R2: exactly ten ticks
    idle(1, 1'b1); idle(9, 1'b1); idle(1, 1'b0);
    rd(16'hBFF8, v);  check("R2 counted ten", 64'(v), 64'd10);
    idle(3, 1'b0);
    rd(16'hBFF8, v);  check("R2 hold without tick", 64'(v), 64'd10);
    // R3: high write wins over tick, low half untouched
    op(1'b1, 16'hBFFC, 32'h1, 4'hF, 1'b1);
    rd(16'hBFFC, v);  check("R3 high written", 64'(v), 64'h1);
    rd(16'hBFF8, v);  check("R3 low unchanged by tick", 64'(v), 64'd10);
    op(1'b1, 16'hBFFC, 32'h0, 4'hF, 1'b0);
    op(1'b1, 16'hBFF8, 32'h0, 4'hF, 1'b0);
    // R5: threshold on hart0
    op(1'b1, 16'h4004, 32'h0, 4'hF, 1'b0);
    op(1'b1, 16'h4000, 32'd20, 4'hF, 1'b0);
    idle(1, 1'b0);
    check("R5 below compare", 64'(irq[0]), 64'h0);
    idle(21, 1'b1); idle(1, 1'b0);
    check("R5 reached compare", 64'(irq[0]), 64'h1);
    op(1'b1, 16'h4000, 32'd1000, 4'hF, 1'b0);
    idle(1, 1'b0);
    check("R5 cleared after larger compare", 64'(irq[0]), 64'h0);
    // R6: byte strobes
    op(1'b1, 16'h4008, 32'hAABBCCDD, 4'hF, 1'b0);
    op(1'b1, 16'h4008, 32'h11223344, 4'b0101, 1'b0);
    rd(16'h4008, v);  check("R6 partial strobe", 64'(v), 64'hAA22CC44);
    // R9: other harts untouched
    rd(16'h4000, v);  check("R9 hart0 kept", 64'(v), 64'd1000);
    rd(16'h4010, v);  check("R9 hart2 kept", 64'(v), 64'hFFFFFFFF);
    // R4: high half of hart2
    op(1'b1, 16'h4014, 32'h00000123, 4'hF, 1'b0);
    rd(16'h4014, v);  check("R4 hart2 high", 64'(v), 64'h123);
    // R7: beyond hart count, last slot, outside map
    op(1'b1, 16'h4018, 32'h0, 4'hF, 1'b0);
    rd(16'h4018, v);  check("R7 hart3 reads zero", 64'(v), 64'h0);
    op(1'b1, 16'hBFF0, 32'h0, 4'hF, 1'b0);
    rd(16'hBFF0, v);  check("R7 slot 4094 reads zero", 64'(v), 64'h0);
    op(1'b1, 16'h0000, 32'h0, 4'hF, 1'b0);
    rd(16'h0000, v);  check("R7 low unmapped", 64'(v), 64'h0);
    rd(16'hC000, v);  check("R7 high unmapped", 64'(v), 64'h0);
    rd(16'h4000, v);  check("R7 hart0 not aliased", 64'(v), 64'd1000);
    // random mix, checked by the monitor against the model
    for (int i = 0; i < 3000; i++) begin
      int          r;
      logic [15:0] a;
      logic [31:0] d;
      r = int'($urandom % 8);
      case (r)
        0, 1:       a = 16'hBFF8 | 16'($urandom % 2) << 2;
        2, 3, 4, 5: a = 16'h4000 + 16'(($urandom % 5) * 8) + (16'($urandom % 2) << 2);
        6:          a = 16'($urandom % 16'h4000) & 16'hFFFC;
        default:    a = 16'hC000 | (16'($urandom % 16'h4000) & 16'hFFFC);
      endcase
      if (a[2]) d = ($urandom % 8 == 0) ? $urandom : 32'h0;
      else      d = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 256);
      if ($urandom % 3 == 0) idle(1, 1'($urandom % 2));
      else op(1'($urandom % 2), a, d, 4'($urandom), 1'($urandom % 2));
    end
    idle(3, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule